// File: doc/BRIEF.md
# Framed Serial Transmitter with Lock Handshake

This block sits on the converter side of a single-lane serial link. It takes parallel samples of `DATA_W` bits and sends them out one bit per clock. After reset, and whenever the far end reports that it has lost lock, it sends a balanced training waveform: a run of ones followed by an equally long run of zeros, repeated. The receiver's clock recovery can lock to that waveform and then raise `lock_in`.

While lock is held, every accepted sample goes out as one frame. A frame is a start bit of one, then the sample bits with the most significant bit first, then a stop bit of zero. So a sample costs `DATA_W+2` bit times, and the bit clock must run at `DATA_W+2` times the sample rate. The lock line is synchronised inside the block. A change of lock takes effect only when a frame or a training period ends, so the line never carries a truncated frame or a truncated training period.

The producer sees a `ready`/`sample_valid` handshake backed by a single holding slot. This lets frames follow each other with no gap. `sync_mode` tells the system which of the two waveforms is on the line.

Top module: `serial_frame_tx`

## Requirements
- R1: While `rst` is high the outputs settle to `ser_out`=1, `sync_mode`=1 and `ready`=0.
- R2: While `sync_mode` is high, `ser_out` repeats a period of H ones then H zeros, where H=floor((DATA_W+2)/2). Each training spell starts at the beginning of a period, with ones.
- R3: `lock_in` passes through two flip-flops. A rise of `lock_in` ends training between 3 and 2H+2 clock edges later, and only after a complete training period (its last bit is a zero).
- R4: A frame on `ser_out` is a 1, then the DATA_W sample bits with the MSB first, then a 0, for DATA_W+2 bit times in all.
- R5: `ready` is high only in data mode with the holding slot empty. A sample whose `sample_valid` is high at an edge where `ready` is high is accepted, and `ready` is low in the following cycle.
- R6: If the next sample is accepted before the current frame's stop bit, its start bit follows the stop bit with no idle bit. This gives one sample per DATA_W+2 clocks.
- R7: In data mode with no pending sample, `ser_out` stays 0. A sample accepted at edge t drives its start bit on `ser_out` after edge t+1.
- R8: A fall of `lock_in` during a frame lets that frame finish, and training starts right after its stop bit. A fall while idle starts training 3 edges later.
- R9: `sample_valid` while `ready` is low, including during training, has no effect: no frame for that word ever appears.
- R10: `sync_mode` is high exactly while the training waveform is on `ser_out`. When training restarts, its first bit (a 1) follows a 0 on the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| sample | input | DATA_W | Sample word to send |
| sample_valid | input | 1 | Sample word is offered this cycle |
| lock_in | input | 1 | Receiver lock indication, asynchronous |
| ready | output | 1 | Holding slot can take a sample |
| ser_out | output | 1 | Serial bit stream |
| sync_mode | output | 1 | Training waveform is being sent |

## Verification
If the sequencer's bit counter or state is wrong, the error reaches `ser_out` on the very next bit. It shows as a run of the wrong length in the training waveform, a missing stop zero, or a frame whose data no longer matches the queued sample. A holding slot that is wrongly full or empty shows within one frame: either a frame appears that has no queued sample, or an idle gap appears inside a burst. A fault in the lock path or in the boundary rule shows as a latency outside the R3/R8 window, or as `sync_mode` switching in the middle of a frame or a training period.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  typedef enum logic [1:0] {
    ST_TRAIN = 2'd0,
    ST_IDLE  = 2'd1,
    ST_FRAME = 2'd2
  } tx_state_e;

  function automatic int frame_bits(input int w);
    return w + 2;
  endfunction

  function automatic int train_run(input int w);
    return (w + 2) / 2;
  endfunction

endpackage

// File: rtl/sertx_lock_sync.sv
module sertx_lock_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], async_in};
  end

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/sertx_hold.sv
module sertx_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] in_data,
  input  logic         in_valid,
  input  logic         take,
  input  logic         flush,
  output logic         ready,
  output logic         full,
  output logic [W-1:0] data
);
  logic         accept;
  logic         full_n;
  logic         ready_n;

  assign accept = in_valid && ready;

  always_comb begin
    if (flush)       full_n = 1'b0;
    else if (accept) full_n = 1'b1;
    else if (take)   full_n = 1'b0;
    else             full_n = full;
    ready_n = !flush && !full_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      full  <= 1'b0;
      ready <= 1'b0;
      data  <= '0;
    end else begin
      full  <= full_n;
      ready <= ready_n;
      if (accept) data <= in_data;
    end
  end
endmodule

// File: rtl/sertx_seq.sv
module sertx_seq
  import sertx_pkg::*;
#(
  parameter int W     = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lock_ok,
  input  logic             hold_full,
  input  logic [W-1:0]     hold_data,
  output logic             take,
  output logic             flush,
  output tx_state_e        state,
  output logic [CNT_W-1:0] cnt,
  output logic             ser_out,
  output logic             sync_mode
);
  localparam int FRAME_LAST = frame_bits(W) - 1;
  localparam int HALF       = train_run(W);
  localparam int TRAIN_LAST = 2 * HALF - 1;

  tx_state_e        st_n;
  logic [CNT_W-1:0] cnt_n;
  logic [W-1:0]     word_q, word_n;
  logic             bound;
  logic             bit_n;

  function automatic logic data_bit(input logic [W-1:0] w, input logic [CNT_W-1:0] pos);
    logic b;
    b = 1'b0;
    for (int i = 0; i < W; i++)
      if (pos == CNT_W'(i + 1)) b = w[W-1-i];
    return b;
  endfunction

  always_comb begin
    st_n   = state;
    cnt_n  = cnt;
    word_n = word_q;
    take   = 1'b0;
    bound  = 1'b0;
    case (state)
      ST_TRAIN: bound = (cnt == CNT_W'(TRAIN_LAST));
      ST_FRAME: bound = (cnt == CNT_W'(FRAME_LAST));
      default:  bound = 1'b1;
    endcase
    if (!bound) begin
      cnt_n = cnt + 1'b1;
    end else begin
      cnt_n = '0;
      if (!lock_ok) begin
        st_n = ST_TRAIN;
      end else if (hold_full) begin
        st_n   = ST_FRAME;
        word_n = hold_data;
        take   = 1'b1;
      end else begin
        st_n = ST_IDLE;
      end
    end
    flush = (st_n == ST_TRAIN);
    case (st_n)
      ST_TRAIN: bit_n = (cnt_n < CNT_W'(HALF));
      ST_FRAME: begin
        if (cnt_n == '0)                         bit_n = 1'b1;
        else if (cnt_n == CNT_W'(FRAME_LAST))    bit_n = 1'b0;
        else                                     bit_n = data_bit(word_n, cnt_n);
      end
      default:  bit_n = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_TRAIN;
      cnt       <= '0;
      word_q    <= '0;
      ser_out   <= 1'b1;
      sync_mode <= 1'b1;
    end else begin
      state     <= st_n;
      cnt       <= cnt_n;
      word_q    <= word_n;
      ser_out   <= bit_n;
      sync_mode <= (st_n == ST_TRAIN);
    end
  end
endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
  import sertx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int SYNC_FFS  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] sample,
  input  logic              sample_valid,
  input  logic              lock_in,
  output logic              ready,
  output logic              ser_out,
  output logic              sync_mode
);
  localparam int CNT_W = $clog2(frame_bits(DATA_W));

  logic              lock_ok;
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              take;
  logic              flush;
  tx_state_e         seq_state;
  logic [CNT_W-1:0]  seq_cnt;

  sertx_lock_sync #(.STAGES(SYNC_FFS)) u_lock (
    .clk      (clk),
    .rst      (rst),
    .async_in (lock_in),
    .sync_out (lock_ok)
  );

  sertx_hold #(.W(DATA_W)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .in_data  (sample),
    .in_valid (sample_valid),
    .take     (take),
    .flush    (flush),
    .ready    (ready),
    .full     (hold_full),
    .data     (hold_data)
  );

  sertx_seq #(.W(DATA_W), .CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .lock_ok   (lock_ok),
    .hold_full (hold_full),
    .hold_data (hold_data),
    .take      (take),
    .flush     (flush),
    .state     (seq_state),
    .cnt       (seq_cnt),
    .ser_out   (ser_out),
    .sync_mode (sync_mode)
  );
endmodule

// File: rtl/serial_frame_tx_chk.sv
module serial_frame_tx_chk
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             sample_valid,
  input logic             lock_in,
  input logic             ready,
  input logic             ser_out,
  input logic             sync_mode,
  input logic             lock_ok,
  input tx_state_e        seq_state,
  input logic [CNT_W-1:0] seq_cnt
);
  localparam int FRAME_LAST = frame_bits(DATA_W) - 1;

  logic [1:0] warm_q;
  always_ff @(posedge clk) begin
    if (rst)               warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  p_ready_train_r5: assert property (@(posedge clk) disable iff (rst)
    sync_mode |-> !ready);

  p_accept_drop_r5: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && ready) |=> !ready);

  p_lock_delay_r3: assert property (@(posedge clk) disable iff (rst)
    (warm_q >= 2'd2) |-> (lock_ok == $past(lock_in, 2)));

  p_leave_train_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(sync_mode) |-> !$past(ser_out));

  p_start_bit_r4: assert property (@(posedge clk) disable iff (rst)
    (seq_state == ST_FRAME && seq_cnt == '0) |-> ser_out);

  p_stop_bit_r4: assert property (@(posedge clk) disable iff (rst)
    (seq_state == ST_FRAME && seq_cnt == CNT_W'(FRAME_LAST)) |-> !ser_out);

  p_idle_low_r7: assert property (@(posedge clk) disable iff (rst)
    (seq_state == ST_IDLE) |-> !ser_out);

  p_enter_train_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_mode) |-> (ser_out && !$past(ser_out)));
endmodule

bind serial_frame_tx serial_frame_tx_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .sample_valid (sample_valid),
  .lock_in      (lock_in),
  .ready        (ready),
  .ser_out      (ser_out),
  .sync_mode    (sync_mode),
  .lock_ok      (lock_ok),
  .seq_state    (seq_state),
  .seq_cnt      (seq_cnt)
);

// File: tb/test_serial_frame_tx.sv
module test_serial_frame_tx;
  localparam int W       = 8;
  localparam int FLEN    = W + 2;
  localparam int HALF    = FLEN / 2;
  localparam int SPER    = 2 * HALF;
  localparam time CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] sample = '0;
  logic         sample_valid = 1'b0;
  logic         lock_in = 1'b0;
  logic         ready, ser_out, sync_mode;

  int checks = 0;
  int fails  = 0;
  logic [W-1:0] exp_q[$];

  logic         mon_in_frame = 1'b0;
  logic         prev_sync = 1'b1;
  int           phase = 0;
  int           fbits = 0;
  logic [W-1:0] fword = '0;
  int           idle_run = 0;
  int           frame_count = 0;
  logic         burst_on = 1'b0;
  int           burst_frames = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_frame_tx #(.DATA_W(W)) i_serial_frame_tx (
    .clk(clk), .rst(rst), .sample(sample), .sample_valid(sample_valid),
    .lock_in(lock_in), .ready(ready), .ser_out(ser_out), .sync_mode(sync_mode)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (sync_mode) begin
        if (!prev_sync) begin
          chk(!mon_in_frame, "R8 training began inside a frame", int'(mon_in_frame), 0);
          phase = 0;
          mon_in_frame = 1'b0;
        end
        chk(ser_out == (phase < HALF), "R2 training bit", int'(ser_out), int'(phase < HALF));
        chk(!ready, "R5 ready during training", int'(ready), 0);
        phase = (phase + 1) % SPER;
      end else begin
        if (prev_sync) chk(phase == 0, "R3 training period cut short", phase, 0);
        if (!mon_in_frame) begin
          if (ser_out) begin
            if (burst_on && burst_frames > 0)
              chk(idle_run == 0, "R6 gap between burst frames", idle_run, 0);
            mon_in_frame = 1'b1;
            fbits = 0;
          end else begin
            idle_run++;
          end
        end else if (fbits < W) begin
          fword = {fword[W-2:0], ser_out};
          fbits++;
        end else begin
          chk(!ser_out, "R4 stop bit", int'(ser_out), 0);
          if (exp_q.size() == 0) begin
            chk(1'b0, "R9 unexpected frame", int'(fword), -1);
          end else begin
            logic [W-1:0] e;
            e = exp_q.pop_front();
            chk(fword == e, "R4 frame data", int'(fword), int'(e));
          end
          frame_count++;
          if (burst_on) burst_frames++;
          mon_in_frame = 1'b0;
          idle_run = 0;
        end
      end
      prev_sync = sync_mode;
    end
  end

  task automatic send_word(input logic [W-1:0] w);
    @(negedge clk);
    while (!ready) @(negedge clk);
    sample = w;
    sample_valid = 1'b1;
    exp_q.push_back(w);
    @(negedge clk);
    sample_valid = 1'b0;
  endtask

  task automatic drain();
    for (int k = 0; k < 3000 && (exp_q.size() != 0 || mon_in_frame); k++) @(negedge clk);
    chk(exp_q.size() == 0, "R4 all queued frames sent", exp_q.size(), 0);
  endtask

  task automatic raise_lock();
    int n;
    n = 0;
    @(negedge clk);
    lock_in = 1'b1;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (sync_mode && n < 100);
    chk(n >= 3 && n <= SPER + 2, "R3 lock-to-data latency", n, SPER + 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(ser_out == 1'b1, "R1 reset ser_out", int'(ser_out), 1);
    chk(sync_mode == 1'b1, "R1 reset sync_mode", int'(sync_mode), 1);
    chk(ready == 1'b0, "R1 reset ready", int'(ready), 0);
    @(posedge clk); #1 rst = 1'b0;

    repeat (25) @(negedge clk);
    // R9: offer a word during training
    sample = 8'h3C;
    sample_valid = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!ready, "R9 ready low while training", int'(ready), 0);
    end
    sample_valid = 1'b0;

    raise_lock();
    repeat (30) @(negedge clk);
    chk(frame_count == 0, "R9 dropped word never framed", frame_count, 0);
    chk(!ser_out, "R7 idle line low", int'(ser_out), 0);
    chk(ready, "R5 ready in idle data mode", int'(ready), 1);

    // R7 latency
    sample = 8'hA5;
    sample_valid = 1'b1;
    exp_q.push_back(8'hA5);
    @(posedge clk);
    @(negedge clk);
    sample_valid = 1'b0;
    chk(!ready, "R5 ready low after accept", int'(ready), 0);
    chk(!ser_out, "R7 no start at t", int'(ser_out), 0);
    @(negedge clk);
    chk(ser_out, "R7 start after t+1", int'(ser_out), 1);
    drain();

    // R6 burst
    repeat (5) @(negedge clk);
    burst_on = 1'b1;
    burst_frames = 0;
    send_word(8'h00); send_word(8'hFF); send_word(8'h80);
    send_word(8'h01); send_word(8'h5A); send_word(8'hC3);
    drain();
    burst_on = 1'b0;
    chk(burst_frames == 6, "R6 burst frame count", burst_frames, 6);

    // R8 lock loss mid-frame
    repeat (4) @(negedge clk);
    send_word(8'h96);
    while (!ser_out) @(negedge clk);
    repeat (3) @(negedge clk);
    lock_in = 1'b0;
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (!sync_mode && n < 100);
    chk(n <= FLEN + 2, "R8 mid-frame lock loss latency", n, FLEN + 2);
    chk(exp_q.size() == 0, "R8 frame finished before training", exp_q.size(), 0);

    repeat (25) @(negedge clk);
    raise_lock();

    // R8 lock loss while idle
    repeat (15) @(negedge clk);
    lock_in = 1'b0;
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (!sync_mode && n < 100);
    chk(n == 3, "R8 idle lock loss latency", n, 3);
    chk(ser_out, "R10 training restarts with one", int'(ser_out), 1);

    repeat (12) @(negedge clk);
    raise_lock();
    send_word(8'h7E);
    send_word(8'h24);
    drain();
    repeat (5) @(negedge clk);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule